// File: doc/BRIEF.md
# Buffer RAM Access Port with DMA Request Handshake

This block gives a host processor byte access to a 2048 x 8 buffer RAM through four byte-wide registers. The host loads an 11-bit pointer through a low byte and a high byte, then reads or writes RAM bytes through one data register. Three flags sit in the high byte next to the top address bits: a direction flag, an auto-increment flag and a DMA enable. In read direction the byte at the pointer is fetched into the data register as soon as the pointer moves, so a read returns data with no wait.

When DMA is enabled, a write of the low pointer byte raises a request to an external DMA controller. Each acknowledged strobe moves one byte through the data register, in the direction set by the direction flag, and follows the same auto-increment rule as host accesses. A terminal count ends the transfer. Clearing the enable cancels a transfer at any time. The enable clears itself when a transfer finishes, and its inverse is the end-of-transfer interrupt source. That source is gated by a mask bit that a command can clear.

The request logic is a state machine with five states. IDLE moves to REQ on arm (a low-byte write with the enable set). REQ moves to ACK on a raised acknowledge. It moves to LAST on a strobe with terminal count. ACK returns to REQ when the acknowledge drops, and moves to LAST on a strobe with terminal count. LAST moves to IDLE on acknowledge negation and clears the enable (done). Any busy state with the enable cleared goes to ABORT while the acknowledge is high, or straight to IDLE when it is low. ABORT moves to IDLE on acknowledge negation.

Top module: `buf_ptr_dma`

## Requirements
- R1: After reset, the pointer is 0, all high-byte flags are 0, the data register is 0x00, the interrupt mask is 0, and dma_req and irq are low.
- R2: Select 1 is the high byte. Bit 7 is direction (1 = read), bit 6 is auto-increment, bit 3 is DMA enable, and bits 2-0 are pointer bits 10-8. Bits 5-4 read as 0 whatever is written. Select 0 is the low byte of the pointer.
- R3: In write direction, a host write to select 2 stores the byte at the pointer. With auto-increment set, the pointer then advances by one.
- R4: In read direction, select 2 returns the byte at the pointer from the cycle after any pointer write. A read with auto-increment set returns that byte and leaves the next byte ready for the following cycle.
- R5: With auto-increment clear, data accesses leave the pointer unchanged, and repeated reads return the same byte.
- R6: Incrementing from 0x7FF gives 0x000.
- R7: A low-byte write while DMA enable is 1 raises dma_req from the next cycle. A low-byte write while the enable is 0 leaves dma_req low.
- R8: While the request is active, each cycle with dma_ack and dma_stb both high transfers one byte. In read direction the byte comes from dma_rdata, and in write direction dma_wdata is stored at the pointer. Auto-increment applies as for host accesses.
- R9: A strobe with dma_tc high drops dma_req from the next cycle. The DMA enable stays 1 until dma_ack goes low, and it is 0 from the cycle after that.
- R10: Writing the high byte with bit 3 clear drops dma_req from the next cycle. Strobes under the still-high acknowledge are then ignored, and a new request needs a new arm.
- R11: Select 3 reads back bit 0 = end flag (inverse of DMA enable) and bit 1 = mask. irq equals mask AND end flag.
- R12: A write to select 3 with bit 7 clear loads the mask from bit 0. The command byte 0x81 clears the mask. Any other byte with bit 7 set leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select: 0 low byte, 1 high byte, 2 data, 3 interrupt |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Contents of the selected register |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge |
| dma_stb | input | 1 | DMA byte strobe, valid with dma_ack |
| dma_tc | input | 1 | Terminal count, sampled with a strobe |
| dma_wdata | input | 8 | DMA data into the RAM |
| dma_rdata | output | 8 | DMA data out of the data register |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The bench targets the pointer wrap at 0x7FF. A design that carries into a twelfth bit or saturates would read back the wrong low byte and fetch the wrong byte next. It checks that a read returns the prefetched byte in the same cycle as the strobe. An off-by-one prefetch would return the previous or the following byte. It cancels a transfer with the acknowledge still high, then issues a strobe. A design that kept transferring would move the pointer and change RAM, and both show up on later readback. It also checks that the enable survives the terminal-count strobe until the acknowledge drops, that low-byte writes do not arm while the enable is clear, and that only command byte 0x81 clears the mask.

// File: rtl/bufptr_pkg.sv
package bufptr_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned PTR_W    = 11;
    localparam int unsigned RAM_WORDS = 1 << PTR_W;

    // high pointer byte field positions
    localparam int unsigned HB_DIR = 7;
    localparam int unsigned HB_INC = 6;
    localparam int unsigned HB_DEN = 3;

    localparam logic [BYTE_W-1:0] CMD_MASK_CLR = 8'h81;

    typedef enum logic [1:0] {
        RS_PLO  = 2'd0,
        RS_PHI  = 2'd1,
        RS_DATA = 2'd2,
        RS_INTR = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        DS_IDLE,
        DS_REQ,
        DS_ACK,
        DS_LAST,
        DS_ABORT
    } dma_state_e;
endpackage

// File: rtl/bp_ptr_regs.sv
module bp_ptr_regs
    import bufptr_pkg::*;
#(
    parameter int unsigned AW = PTR_W,
    parameter int unsigned DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    host_sel,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    input  logic          dma_xfer,
    input  logic          dma_done,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_nxt,
    output logic          rd_mode,
    output logic          auto_inc,
    output logic          dma_en,
    output logic          end_mask,
    output logic          arm,
    output logic          mem_we,
    output logic          reload
);
    localparam int unsigned HI_W = AW - DW;

    logic plo_wr, phi_wr, intr_wr, data_acc, acc, ptr_wr, step, rd_nxt;

    always_comb begin
        plo_wr   = host_wr && (host_sel == RS_PLO);
        phi_wr   = host_wr && (host_sel == RS_PHI);
        intr_wr  = host_wr && (host_sel == RS_INTR);
        data_acc = (host_wr || host_rd) && (host_sel == RS_DATA);
        acc      = data_acc || dma_xfer;
        mem_we   = dma_xfer ? !rd_mode : (data_acc && host_wr);
        ptr_wr   = plo_wr || phi_wr;
        step     = acc && auto_inc && !ptr_wr;
        rd_nxt   = phi_wr ? host_wdata[HB_DIR] : rd_mode;
        arm      = plo_wr && dma_en;
    end

    always_comb begin
        ptr_nxt = ptr;
        if (plo_wr)
            ptr_nxt = {ptr[AW-1:DW], host_wdata};
        else if (phi_wr)
            ptr_nxt = {host_wdata[HI_W-1:0], ptr[DW-1:0]};
        else if (step)
            ptr_nxt = ptr + {{(AW-1){1'b0}}, 1'b1};
        reload = (ptr_wr || step) && rd_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            rd_mode  <= 1'b0;
            auto_inc <= 1'b0;
            dma_en   <= 1'b0;
            end_mask <= 1'b0;
        end else begin
            ptr     <= ptr_nxt;
            rd_mode <= rd_nxt;
            if (phi_wr) begin
                auto_inc <= host_wdata[HB_INC];
                dma_en   <= host_wdata[HB_DEN];
            end else if (dma_done) begin
                dma_en <= 1'b0;
            end
            if (intr_wr) begin
                if (!host_wdata[DW-1])
                    end_mask <= host_wdata[0];
                else if (host_wdata == CMD_MASK_CLR)
                    end_mask <= 1'b0;
            end
        end
    end

    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && auto_inc && !ptr_wr && (ptr == {AW{1'b1}})) |=> (ptr == '0));
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !auto_inc && !ptr_wr) |=> $stable(ptr));
    a_r12_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_wr && host_wdata == CMD_MASK_CLR) |=> !end_mask);
    a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (phi_wr && !host_wdata[HB_DEN]) |=> !dma_en);
endmodule

// File: rtl/bp_buf_ram.sv
module bp_buf_ram
    import bufptr_pkg::*;
#(
    parameter int unsigned AW = PTR_W,
    parameter int unsigned DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          reload,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] dreg
);
    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            dreg <= '0;
        else if (reload)
            dreg <= mem[raddr];
    end
endmodule

// File: rtl/bp_dma_fsm.sv
module bp_dma_fsm
    import bufptr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic dma_en,
    input  logic dack,
    input  logic dstb,
    input  logic tc,
    output logic dreq,
    output logic xfer,
    output logic done
);
    dma_state_e st, st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= DS_IDLE;
        else
            st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            DS_IDLE: if (arm) st_nxt = DS_REQ;
            DS_REQ: begin
                if (!dma_en)         st_nxt = dack ? DS_ABORT : DS_IDLE;
                else if (xfer && tc) st_nxt = DS_LAST;
                else if (dack)       st_nxt = DS_ACK;
            end
            DS_ACK: begin
                if (!dma_en)         st_nxt = dack ? DS_ABORT : DS_IDLE;
                else if (xfer && tc) st_nxt = DS_LAST;
                else if (!dack)      st_nxt = DS_REQ;
            end
            DS_LAST: begin
                if (!dma_en)         st_nxt = dack ? DS_ABORT : DS_IDLE;
                else if (!dack)      st_nxt = DS_IDLE;
            end
            DS_ABORT: if (!dack) st_nxt = DS_IDLE;
            default:  st_nxt = DS_IDLE;
        endcase
    end

    always_comb begin
        dreq = ((st == DS_REQ) || (st == DS_ACK)) && dma_en;
        xfer = dack && dstb && dreq;
        done = (st == DS_LAST) && !dack && dma_en;
    end

    a_r9_tc_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && tc) |=> !dreq);
    a_r7_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && st == DS_IDLE) |=> dreq);
    a_r10_abort_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (st == DS_ABORT && dack) |=> (st == DS_ABORT || st == DS_IDLE) && !dreq);
endmodule

// File: rtl/buf_ptr_dma.sv
module buf_ptr_dma
    import bufptr_pkg::*;
#(
    parameter int unsigned AW = PTR_W,
    parameter int unsigned DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    host_sel,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          dma_req,
    input  logic          dma_ack,
    input  logic          dma_stb,
    input  logic          dma_tc,
    input  logic [DW-1:0] dma_wdata,
    output logic [DW-1:0] dma_rdata,
    output logic          irq
);
    localparam int unsigned HI_W = AW - DW;

    logic [AW-1:0] ptr, ptr_nxt;
    logic          rd_mode, auto_inc, dma_en, end_mask;
    logic          arm, mem_we, reload, xfer, done;
    logic [DW-1:0] dreg, ram_wdata;

    bp_ptr_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata),
        .dma_xfer(xfer), .dma_done(done),
        .ptr(ptr), .ptr_nxt(ptr_nxt),
        .rd_mode(rd_mode), .auto_inc(auto_inc), .dma_en(dma_en),
        .end_mask(end_mask), .arm(arm), .mem_we(mem_we), .reload(reload)
    );

    assign ram_wdata = xfer ? dma_wdata : host_wdata;

    bp_buf_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(ptr), .wdata(ram_wdata),
        .reload(reload), .raddr(ptr_nxt), .dreg(dreg)
    );

    bp_dma_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .arm(arm), .dma_en(dma_en),
        .dack(dma_ack), .dstb(dma_stb), .tc(dma_tc),
        .dreq(dma_req), .xfer(xfer), .done(done)
    );

    always_comb begin
        host_rdata = '0;
        unique case (reg_sel_e'(host_sel))
            RS_PLO:  host_rdata = ptr[DW-1:0];
            RS_PHI: begin
                host_rdata[HB_DIR]     = rd_mode;
                host_rdata[HB_INC]     = auto_inc;
                host_rdata[HB_DEN]     = dma_en;
                host_rdata[HI_W-1:0]   = ptr[AW-1:DW];
            end
            RS_DATA: host_rdata = dreg;
            RS_INTR: host_rdata = {{(DW-2){1'b0}}, end_mask, !dma_en};
            default: host_rdata = '0;
        endcase
    end

    assign dma_rdata = dreg;
    assign irq       = end_mask && !dma_en;

    a_r11_irq_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && end_mask && !(host_wr && host_sel == RS_INTR)) |=> irq);
    a_r9_en_held: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && dma_tc && dma_ack && !(host_wr && host_sel == RS_PHI)) |=> dma_en);
endmodule

// File: tb/tb_buf_ptr_dma.sv
module tb_buf_ptr_dma;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00, dma_wdata = 8'h00;
    logic       dma_ack = 1'b0, dma_stb = 1'b0, dma_tc = 1'b0;
    wire  [7:0] host_rdata, dma_rdata;
    wire        dma_req, irq;

    int total = 0, bad = 0;
    string cur_tag = "R1";
    bit fin = 0;

    always #4 clk = ~clk;

    buf_ptr_dma dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_stb(dma_stb), .dma_tc(dma_tc),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .irq(irq)
    );

    // behavioural reference model
    logic [7:0]  m_mem [0:2047];
    logic [10:0] m_ptr;
    logic [7:0]  m_dreg;
    bit m_rd, m_ai, m_en, m_mask;
    int m_st; // 0 idle 1 req 2 ack 3 last 4 abort

    function automatic bit m_dreq();
        return (m_st == 1 || m_st == 2) && m_en;
    endfunction

    function automatic logic [7:0] m_rdata(input logic [1:0] s);
        case (s)
            2'd0: return m_ptr[7:0];
            2'd1: return {m_rd, m_ai, 2'b00, m_en, m_ptr[10:8]};
            2'd2: return m_dreg;
            default: return {6'd0, m_mask, !m_en};
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_dreg = 0; m_rd = 0; m_ai = 0; m_en = 0; m_mask = 0; m_st = 0;
        end else begin
            bit pl, ph, pi, dacc, xf, acc, we, done, step, ptrw, en_old;
            pl = host_wr && host_sel == 2'd0;
            ph = host_wr && host_sel == 2'd1;
            pi = host_wr && host_sel == 2'd3;
            dacc = (host_wr || host_rd) && host_sel == 2'd2;
            xf = dma_ack && dma_stb && m_dreq();
            acc = dacc || xf;
            we = xf ? !m_rd : (dacc && host_wr);
            if (we) m_mem[m_ptr] = xf ? dma_wdata : host_wdata;
            en_old = m_en;
            done = 0;
            case (m_st)
                0: if (pl && en_old) m_st = 1;
                1, 2: begin
                    if (!en_old) m_st = dma_ack ? 4 : 0;
                    else if (xf && dma_tc) m_st = 3;
                    else if (m_st == 1 && dma_ack) m_st = 2;
                    else if (m_st == 2 && !dma_ack) m_st = 1;
                end
                3: begin
                    if (!en_old) m_st = dma_ack ? 4 : 0;
                    else if (!dma_ack) begin m_st = 0; done = 1; end
                end
                default: if (!dma_ack) m_st = 0;
            endcase
            ptrw = pl || ph;
            step = acc && m_ai && !ptrw;
            if (pl) m_ptr[7:0] = host_wdata;
            else if (ph) m_ptr[10:8] = host_wdata[2:0];
            else if (step) m_ptr = m_ptr + 11'd1;
            if (ph) begin
                m_rd = host_wdata[7]; m_ai = host_wdata[6]; m_en = host_wdata[3];
            end else if (done) m_en = 0;
            if ((ptrw || step) && m_rd) m_dreg = m_mem[m_ptr];
            if (pi) begin
                if (!host_wdata[7]) m_mask = host_wdata[0];
                else if (host_wdata == 8'h81) m_mask = 0;
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model every cycle
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            check({cur_tag, " rdata"}, host_rdata, m_rdata(host_sel));
            check({cur_tag, " dreq"}, {7'd0, dma_req}, {7'd0, m_dreq()});
            check({cur_tag, " irq"}, {7'd0, irq}, {7'd0, m_mask && !m_en});
            check({cur_tag, " dma_rdata"}, dma_rdata, m_dreg);
        end
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); #1;
        host_sel = s; host_wr = 1'b1; host_wdata = d;
        @(negedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] s, input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        host_sel = s; host_rd = 1'b1;
        #2 check(tag, host_rdata, exp);
        @(negedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        host_sel = s;
        #2 check(tag, host_rdata, exp);
    endtask

    task automatic strobe(input logic [7:0] d, input bit tc, input bit chk, input logic [7:0] exp,
                          input string tag);
        @(negedge clk); #1;
        dma_stb = 1'b1; dma_tc = tc; dma_wdata = d;
        #2 if (chk) check(tag, dma_rdata, exp);
        @(negedge clk); #1;
        dma_stb = 1'b0; dma_tc = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    initial begin
        #(8 * 200000);
        if (!fin) begin
            fin = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        cur_tag = "R1";
        peek(2'd0, 8'h00, "R1 ptr low");
        peek(2'd1, 8'h00, "R1 high flags");
        peek(2'd2, 8'h00, "R1 data reg");
        peek(2'd3, 8'h01, "R1 status");
        check("R1 dreq", {7'd0, dma_req}, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);

        // R2 reserved bits, then clear
        cur_tag = "R2";
        wr(2'd1, 8'hFF);
        peek(2'd1, 8'hCF, "R2 reserved read zero");
        wr(2'd0, 8'h5C);
        peek(2'd0, 8'h5C, "R2 low byte");
        wr(2'd1, 8'h00);
        check("R2 no request", {7'd0, dma_req}, 8'h00);

        // fill RAM in write mode with auto-increment
        cur_tag = "R3";
        wr(2'd1, 8'h40);
        wr(2'd0, 8'h00);
        for (int i = 0; i < 2048; i++) wr(2'd2, pat(i));
        peek(2'd0, 8'h00, "R3 R6 pointer after full pass");
        wr(2'd0, 8'h10);
        wr(2'd2, 8'hAA); wr(2'd2, 8'hBB); wr(2'd2, 8'hCC);
        peek(2'd0, 8'h13, "R3 pointer advanced");

        // R4 read-ahead
        cur_tag = "R4";
        wr(2'd1, 8'hC0);
        wr(2'd0, 8'h10);
        rd_chk(2'd2, 8'hAA, "R4 first read");
        rd_chk(2'd2, 8'hBB, "R4 second read");
        rd_chk(2'd2, 8'hCC, "R4 third read");
        peek(2'd2, pat(16'h13), "R4 next byte ready");

        // R5 no increment
        cur_tag = "R5";
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h10);
        rd_chk(2'd2, 8'hAA, "R5 read one");
        rd_chk(2'd2, 8'hAA, "R5 read two");
        peek(2'd0, 8'h10, "R5 pointer held");

        // R6 wrap
        cur_tag = "R6";
        wr(2'd1, 8'h47);
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'h5A);
        peek(2'd0, 8'h00, "R6 low after wrap");
        peek(2'd1, 8'h40, "R6 high after wrap");
        wr(2'd1, 8'hC7);
        wr(2'd0, 8'hFF);
        rd_chk(2'd2, 8'h5A, "R6 byte at top");
        peek(2'd2, pat(0), "R6 byte at zero");

        // R11 mask and status
        cur_tag = "R11";
        wr(2'd3, 8'h01);
        peek(2'd3, 8'h03, "R11 status");
        check("R11 irq idle", {7'd0, irq}, 8'h01);

        // R7 arm, R8 DMA write
        cur_tag = "R7";
        wr(2'd1, 8'h48);
        check("R11 irq off when enabled", {7'd0, irq}, 8'h00);
        check("R7 no request before arm", {7'd0, dma_req}, 8'h00);
        wr(2'd0, 8'h20);
        check("R7 request after arm", {7'd0, dma_req}, 8'h01);
        cur_tag = "R8";
        dma_ack = 1'b1;
        strobe(8'h11, 0, 0, 8'h00, "R8");
        strobe(8'h22, 0, 0, 8'h00, "R8");
        cur_tag = "R9";
        strobe(8'h33, 1, 0, 8'h00, "R9");
        check("R9 request dropped", {7'd0, dma_req}, 8'h00);
        peek(2'd1, 8'h48, "R9 enable held under ack");
        dma_ack = 1'b0;
        @(negedge clk); #1;
        peek(2'd1, 8'h40, "R9 enable cleared");
        check("R11 irq at end", {7'd0, irq}, 8'h01);
        peek(2'd0, 8'h23, "R8 pointer after write DMA");

        // R8 DMA read
        cur_tag = "R8";
        wr(2'd1, 8'hC8);
        wr(2'd0, 8'h20);
        dma_ack = 1'b1;
        strobe(8'h00, 0, 1, 8'h11, "R8 dma read 0");
        strobe(8'h00, 0, 1, 8'h22, "R8 dma read 1");
        strobe(8'h00, 1, 1, 8'h33, "R8 dma read 2");
        dma_ack = 1'b0;
        @(negedge clk); #1;
        peek(2'd1, 8'hC0, "R9 enable cleared after read");

        // R10 cancel under ack
        cur_tag = "R10";
        wr(2'd1, 8'h48);
        wr(2'd0, 8'h30);
        dma_ack = 1'b1;
        strobe(8'h44, 0, 0, 8'h00, "R10");
        wr(2'd1, 8'h40);
        check("R10 request dropped", {7'd0, dma_req}, 8'h00);
        strobe(8'h55, 0, 0, 8'h00, "R10");
        peek(2'd0, 8'h31, "R10 ignored strobe kept pointer");
        dma_ack = 1'b0;
        wr(2'd1, 8'hC0);
        wr(2'd0, 8'h30);
        rd_chk(2'd2, 8'h44, "R10 transferred byte");
        rd_chk(2'd2, pat(16'h31), "R10 ignored strobe kept RAM");
        // cancel with ack low, then low write without enable
        wr(2'd1, 8'h48);
        wr(2'd0, 8'h40);
        check("R7 armed again", {7'd0, dma_req}, 8'h01);
        wr(2'd1, 8'h40);
        check("R10 dropped without ack", {7'd0, dma_req}, 8'h00);
        cur_tag = "R7";
        wr(2'd0, 8'h41);
        check("R7 no arm when disabled", {7'd0, dma_req}, 8'h00);

        // R12 mask commands
        cur_tag = "R12";
        wr(2'd3, 8'h85);
        peek(2'd3, 8'h03, "R12 other command ignored");
        wr(2'd3, 8'h81);
        peek(2'd3, 8'h01, "R12 clear command");
        check("R12 irq cleared", {7'd0, irq}, 8'h00);
        wr(2'd3, 8'h01);
        check("R12 mask load", {7'd0, irq}, 8'h01);

        @(negedge clk);
        fin = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule